// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers interrupt requests from a set of sources and keeps a sticky pending flag for each one. A few sources come from external pins and the rest are single-cycle set strobes from peripherals. Each flag is combined with a per-source enable bit and a 3-bit programmable level. The block then selects the most urgent pending source and presents a request with its vector number to the processor core. A source can only win when its level is strictly above the current CPU level.

Software programs the block through a small word-addressed register interface. It can clear flags, set enables and levels, and change the CPU level. It also controls nesting, the alternate vector table select and the polarity of the external pins. A trap indication from the core acts as a read-only fourth CPU level bit. While that bit is set, every user interrupt is blocked. When the core acknowledges a request, the CPU level rises to the level of the accepted source, and arbitration is repeated against the new level on the following cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source's flag is set by its hardware strobe and stays set until software clears it. A write to the flag register (address 0, bit i = source i) clears each flag whose written bit is 0. A written 1 leaves that flag unchanged and never sets it.
- R2: A source whose enable bit (address 1, bit i) is 0 never produces a request, whatever its flag and level.
- R3: The level of source i is held in bits [4*(i%4)+2 : 4*(i%4)] of the level register at address 2 + i/4. The fourth bit of each nibble always reads 0. A source at level 0 never produces a request.
- R4: Among eligible sources, the highest level wins. When levels are equal, the lowest source number wins. `irq_vec` carries the winner's source number.
- R5: The CPU level is held in bits [7:5] of the status register (address 2 + ceil(NSRC/4) + 1). A source is eligible only when its level is strictly greater than this value.
- R6: External pin k sets the flag of source k. The pin passes through two synchronizing flops and an edge detector, so a pin change made before clock edge n shows in the flag after edge n+2. Control bit 2+k selects rising (0) or falling (1) edge.
- R7: Bit 3 of the core register (status address + 1) reflects `trap_lvl`, and writes to that register have no effect. While `trap_lvl` is 1, `irq_req` is 0.
- R8: When control bit 0 (nesting disable) is 1 and an interrupt is in service, `irq_req` is 0. Service begins when `irq_ack` is accepted and ends when `irq_ret` is pulsed.
- R9: When `irq_ack` is high with `irq_req`, the CPU level becomes the accepted source's level after that clock edge. The request is then re-evaluated against the new level.
- R10: Control bit 1 drives `irq_alt`, which selects the alternate vector table.
- R11: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends set.
- R12: After reset, every register reads 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | NEXT | External interrupt pins, asynchronous |
| per_set | input | NSRC-NEXT | Peripheral set strobes for sources NEXT and up |
| trap_lvl | input | 1 | Trap priority active in the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| irq_ack | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Core has finished the interrupt in service |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VW | Vector number of the winning source |
| irq_alt | output | 1 | Alternate vector table select |

## Verification
Random rounds pick enable masks, per-source levels, the CPU level and pending sets, and compare request and vector with a reference arbiter. These rounds separate enable gating, the strict-greater comparison and the choice between highest level and lowest number. Directed tie cases, such as two sources at equal level, expose a reversed scan order. Directed cases also cover level 0, a CPU level equal to the source level, and a set that collides with a clear. Pin tests count the exact synchronizer latency for each polarity. Acknowledge, trap and nesting sequences check the mask changes that follow a taken interrupt.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int NEXT = 2,
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int VW   = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXT-1:0]      ext_pin,
  input  logic [NSRC-NEXT-1:0] per_set,
  input  logic                 trap_lvl,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 irq_ack,
  input  logic                 irq_ret,
  output logic                 irq_req,
  output logic [VW-1:0]        irq_vec,
  output logic                 irq_alt
);
  localparam int NPR    = (NSRC + 3) / 4;
  localparam int A_FLAG = 0;
  localparam int A_EN   = 1;
  localparam int A_PR   = 2;
  localparam int A_CTL  = A_PR + NPR;
  localparam int A_SR   = A_CTL + 1;
  localparam int A_CORE = A_CTL + 2;

  logic [NSRC-1:0] flag, en;
  logic [2:0]      prio [NSRC];
  logic [2:0]      cpu_lvl;
  logic            nest_dis, alt_sel, in_svc;
  logic [NEXT-1:0] pol, s1, s2, s3;
  logic            best_ok;
  logic [VW-1:0]   best_idx;
  logic [2:0]      best_lvl;

  wire [NEXT-1:0] ext_edge = (s2 & ~s3 & ~pol) | (~s2 & s3 & pol);
  wire [NSRC-1:0] hw_set   = {per_set, ext_edge};
  wire wr_flag = reg_we && (reg_addr == AW'(A_FLAG));
  wire wr_en   = reg_we && (reg_addr == AW'(A_EN));
  wire wr_ctl  = reg_we && (reg_addr == AW'(A_CTL));
  wire wr_sr   = reg_we && (reg_addr == AW'(A_SR));
  wire unused_ok = ^{reg_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      flag <= '0; en <= '0; pol <= '0;
      nest_dis <= 1'b0; alt_sel <= 1'b0; in_svc <= 1'b0;
      cpu_lvl <= '0;
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
    end else begin
      s1 <= ext_pin; s2 <= s1; s3 <= s2;
      flag <= (wr_flag ? (flag & reg_wdata[NSRC-1:0]) : flag) | hw_set;
      if (wr_en) en <= reg_wdata[NSRC-1:0];
      for (int i = 0; i < NSRC; i++)
        if (reg_we && reg_addr == AW'(A_PR + i / 4))
          prio[i] <= reg_wdata[4*(i%4) +: 3];
      if (wr_ctl) begin
        nest_dis <= reg_wdata[0];
        alt_sel  <= reg_wdata[1];
        pol      <= reg_wdata[2 +: NEXT];
      end
      if (irq_ret) in_svc <= 1'b0;
      if (irq_ack && irq_req) begin
        cpu_lvl <= best_lvl;
        in_svc  <= 1'b1;
      end else if (wr_sr) begin
        cpu_lvl <= reg_wdata[7:5];
      end
    end
  end

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NSRC; i++)
      if (flag[i] && en[i] && prio[i] > cpu_lvl && (!best_ok || prio[i] > best_lvl)) begin
        best_ok  = 1'b1;
        best_idx = VW'(i);
        best_lvl = prio[i];
      end
  end

  assign irq_req = best_ok && !trap_lvl && !(nest_dis && in_svc);
  assign irq_vec = best_idx;
  assign irq_alt = alt_sel;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_FLAG)) reg_rdata[NSRC-1:0] = flag;
    if (reg_addr == AW'(A_EN))   reg_rdata[NSRC-1:0] = en;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == AW'(A_PR + i / 4)) reg_rdata[4*(i%4) +: 3] = prio[i];
    if (reg_addr == AW'(A_CTL))  reg_rdata[2+NEXT-1:0] = {pol, alt_sel, nest_dis};
    if (reg_addr == AW'(A_SR))   reg_rdata[7:5] = cpu_lvl;
    if (reg_addr == AW'(A_CORE)) reg_rdata[3] = trap_lvl;
  end

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((flag & $past(flag)) == $past(flag)));
  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag[irq_vec] && en[irq_vec]));
  assert_above_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (prio[irq_vec] > cpu_lvl));
  assert_ack_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (cpu_lvl == $past(prio[irq_vec]) && in_svc));
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && per_set[0]) |=> flag[NEXT]);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int NSRC = 8, NEXT = 2, AW = 4, DW = 16, VW = 3;
  localparam int A_PR = 2, A_CTL = 4, A_SR = 5, A_CORE = 6;

  logic clk = 0, rst_n = 0;
  logic [NEXT-1:0] ext_pin = '0;
  logic [NSRC-NEXT-1:0] per_set = '0;
  logic trap_lvl = 0, reg_we = 0, irq_ack = 0, irq_ret = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic irq_req, irq_alt;
  logic [VW-1:0] irq_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  prio_irq_ctrl #(.NSRC(NSRC), .NEXT(NEXT), .AW(AW), .DW(DW), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .per_set(per_set), .trap_lvl(trap_lvl),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec), .irq_alt(irq_alt));

  always #10 clk = ~clk;

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = AW'(a); #1 d = int'(reg_rdata);
  endtask

  task automatic pulse(int m);
    @(negedge clk); per_set = (NSRC-NEXT)'(m);
    @(negedge clk); per_set = '0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic ret();
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
  endtask

  function automatic int model(int fl, int e, int p[NSRC], int lvl);
    int best = -1, bl = 0;
    for (int i = 0; i < NSRC; i++)
      if (fl[i] && e[i] && p[i] > lvl && (best < 0 || p[i] > bl)) begin best = i; bl = p[i]; end
    return best;
  endfunction

  task automatic wr_prio(int p[NSRC]);
    for (int r = 0; r < (NSRC+3)/4; r++) begin
      int d = 0;
      for (int k = 0; k < 4; k++) if (4*r+k < NSRC) d |= p[4*r+k] << (4*k);
      wr(A_PR + r, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, exp;
    int p[NSRC];
    process::self().srandom(7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a <= A_CORE; a++) begin rd(a, v); chk("R12 reset reg", v, 0); end
    chk("R12 reset req", int'(irq_req), 0);

    pulse(1);                      // source 2
    rd(0, v); chk("R1 flag set", v, 'h04);
    wr(0, 'hFF); rd(0, v); chk("R1 write 1 keeps flag", v, 'h04);
    wr(0, 'h08); rd(0, v); chk("R1 write 0 clears, 1 does not set", v, 'h00);

    @(negedge clk); per_set = 1; reg_we = 1; reg_addr = 0; reg_wdata = 0;
    @(negedge clk); per_set = 0; reg_we = 0;
    rd(0, v); chk("R11 set beats clear", v, 'h04);
    wr(0, 0);

    ext_pin[0] = 1;
    @(negedge clk); @(negedge clk); rd(0, v); chk("R6 rising not yet after 2 edges", v & 1, 0);
    @(negedge clk); rd(0, v); chk("R6 rising after 3 edges", v & 1, 1);
    ext_pin[0] = 0;
    wr(A_CTL, 'h08); wr(0, 0);
    ext_pin[1] = 1; repeat (4) @(negedge clk);
    rd(0, v); chk("R6 falling polarity ignores rise", v, 0);
    ext_pin[1] = 0; repeat (3) @(negedge clk);
    rd(0, v); chk("R6 falling polarity sets flag", v, 'h02);
    wr(A_CTL, 'h02); wr(0, 0);
    chk("R10 alt table", int'(irq_alt), 1);
    wr(A_CTL, 0);
    chk("R10 alt table off", int'(irq_alt), 0);

    wr(A_PR, 'hC321); rd(A_PR, v); chk("R3 level field layout", v, 'h4321);
    wr(A_PR, 0); wr(1, 'h04); pulse(1);
    chk("R3 level 0 never requests", int'(irq_req), 0);
    wr(A_PR, 'h0300);
    chk("R2 enabled level 3 requests", int'(irq_req), 1);
    chk("R4 vector 2", int'(irq_vec), 2);
    wr(1, 0); chk("R2 disabled no request", int'(irq_req), 0);
    wr(1, 'h04);
    wr(A_SR, 3 << 5); chk("R5 equal level blocked", int'(irq_req), 0);
    wr(A_SR, 2 << 5); chk("R5 greater level taken", int'(irq_req), 1);
    wr(A_SR, 0);

    trap_lvl = 1; #1;
    rd(A_CORE, v); chk("R7 trap bit reads", v, 'h08);
    chk("R7 trap masks", int'(irq_req), 0);
    wr(A_CORE, 0); rd(A_CORE, v); chk("R7 trap bit write ignored", v, 'h08);
    trap_lvl = 0; #1;

    ack();
    rd(A_SR, v); chk("R9 level raised", v, 3 << 5);
    chk("R9 request drops", int'(irq_req), 0);
    wr(A_PR + 1, 'h0050); wr(1, 'h24); pulse(8);    // source 5 level 5
    chk("R8 preempt allowed", int'(irq_req), 1);
    chk("R4 vector 5", int'(irq_vec), 5);
    wr(A_CTL, 1); chk("R8 nesting disabled", int'(irq_req), 0);
    ret(); chk("R8 after return", int'(irq_req), 1);
    wr(A_CTL, 0); wr(A_SR, 0); wr(0, 0);

    wr(A_PR + 1, 'h0606); wr(1, 'h50); pulse('h14);  // sources 4 and 6 at level 6
    chk("R4 tie lowest number", int'(irq_vec), 4);
    chk("R4 tie request", int'(irq_req), 1);

    for (int it = 0; it < 300; it++) begin
      int e, m, lvl, fl;
      wr(0, 0);
      e = int'($urandom) & 'hFF;
      m = int'($urandom) & 'h3F;
      lvl = int'($urandom) & 7;
      for (int i = 0; i < NSRC; i++) p[i] = int'($urandom) & 7;
      wr(1, e); wr_prio(p); wr(A_SR, lvl << 5); pulse(m);
      fl = m << NEXT;
      exp = model(fl, e, p, lvl);
      chk("R2 R4 R5 random request", int'(irq_req), exp >= 0 ? 1 : 0);
      if (exp >= 0) chk("R4 random vector", int'(irq_vec), exp);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule